// File: doc/BRIEF.md
# Core Timer Chain with Power-On Sequencing

This block is a free-running timer chain for a small controller. A prescaler divides the bus clock into a CPU-cycle enable, one pulse every four clocks. A binary chain advances on that enable. The low eight bits of the chain are the software-visible counter. A higher stage of the same chain produces a periodic one-clock tick for downstream interrupt logic. When the eight-bit counter wraps from 0xFF to 0x00, a sticky overflow flag is set. Software can then extend the count in memory.

The same chain also times the power-on delay. A power-on pulse clears the whole chain, holds the device reset output high and lets the chain count. After 4064 CPU cycles the chain is cleared a second time and the power-on phase ends. From then on, the external reset input clears the chain and the overflow flag for as long as it is held. If external reset is already held when the power-on phase ends, the chain stays at zero until it is released.

Software reads through a request/response stream with one outstanding transfer. A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low while a response is waiting. A response stays valid, with unchanged data, until `rsp_ready_i` accepts it. The counter value is captured when the request is accepted, so a stalled response still returns that value.

Top module: `core_timer`

## Requirements
- R1: While `por_i` is high the counter reads 0x00, the overflow flag and tick are low, no response is pending, `por_active_o` is high and `rst_out_o` is high.
- R2: The counter advances by one every CE_DIV (default 4) bus clocks. After a release from power-on or external reset, the first increment lands on the CE_DIV-th clock edge.
- R3: `por_active_o` stays high for exactly POR_CYCLES × CE_DIV clock edges after `por_i` falls. It falls on the edge where the chain is cleared, so the counter reads 0x00 then. A new `por_i` pulse at any time restarts the whole sequence.
- R4: `ext_rst_i` does not disturb the power-on sequence. If it is high when the power-on phase ends, the counter stays at 0x00 until it falls.
- R5: During normal operation, `ext_rst_i` high clears the counter, prescaler, overflow flag and tick on the next edge, and `rst_out_o` is high while it is held.
- R6: The overflow flag sets on the edge where the counter wraps 0xFF→0x00 in normal operation, and never during the power-on phase.
- R7: A write to address 1 with data bit 0 set clears the overflow flag. A write with bit 0 clear leaves it unchanged. A wrap on the same edge as the clear wins, and the flag stays set.
- R8: Writes to address 0 (the counter) are ignored, and counting continues undisturbed.
- R9: `tick_o` pulses high for one clock each time chain bits [TICK_STAGE-1:0] roll over to zero in normal operation. That is once every 2^TICK_STAGE CPU cycles, with the first pulse 2^TICK_STAGE × CE_DIV edges after release.
- R10: Each accepted request yields exactly one response. `req_ready_o` is low while a response is pending. `rsp_data_o` and `rsp_valid_o` hold steady until `rsp_ready_i` is high.
- R11: A read of address 0 returns the counter value present at the accepting edge. A read of address 1 returns the overflow flag in bit 0 with the other bits zero. A write returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| por_i | input | 1 | Power-on pulse, asynchronous, active high; restarts the sequence |
| ext_rst_i | input | 1 | External reset request, synchronous, active high |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 1 | 0 = counter, 1 = status (bit 0 overflow flag / clear) |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted when high together with valid |
| rsp_data_o | output | 8 | Response data |
| count_o | output | 8 | Current counter value |
| tof_o | output | 1 | Sticky overflow flag |
| tick_o | output | 1 | Periodic one-clock tick |
| por_active_o | output | 1 | High during the power-on delay |
| rst_out_o | output | 1 | Device reset: power-on phase or external reset |

## Verification
The properties assume the following about the inputs:
- `por_i` is high before the first clock edge.
- Every input changes away from the rising edge.
- Request fields stay steady while `req_valid_i` is high.

The bench drives all inputs on falling edges, holds `por_i` from time zero, and presents each request for exactly the cycle it is accepted. Its reference model follows the power-on, hold and run phases cycle by cycle. Directed sequences line up the corner cases: an external reset pulse in the middle of the power-on delay, external reset held across the release, a status clear issued on the very edge of a wrap, and a power-on pulse in mid-run.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int unsigned CNT_W       = 8;
  localparam int unsigned TOF_CLR_BIT = 0;

  typedef logic [CNT_W-1:0] cnt_t;

  // Register addresses on the request stream
  localparam logic REG_COUNT  = 1'b0;
  localparam logic REG_STATUS = 1'b1;

  typedef enum logic [1:0] {
    PH_POWERUP = 2'd0,
    PH_HELD    = 2'd1,
    PH_RUN     = 2'd2
  } phase_e;

  typedef struct packed {
    logic write;
    logic addr;
    cnt_t wdata;
  } bus_req_t;

endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic clear_i,
  output logic ce_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign ce_o = (pre_q == LAST);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      pre_q <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
    end else if (ce_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctmr_chain.sv
module ctmr_chain #(
  parameter int unsigned CHAIN_W    = 14,
  parameter int unsigned LO_W       = 10,
  parameter int unsigned POR_CYCLES = 4064
) (
  input  logic            clk_i,
  input  logic            por_i,
  input  logic            ce_i,
  input  logic            hold_i,
  output logic [LO_W-1:0] lo_o,
  output logic            por_active_o
);
  localparam logic [CHAIN_W-1:0] POR_LAST = CHAIN_W'(POR_CYCLES - 1);

  logic [CHAIN_W-1:0] chain_q;
  logic               pa_q;
  logic               por_done;

  // The chain doubles as the power-on delay counter
  assign por_done     = pa_q && ce_i && (chain_q == POR_LAST);
  assign lo_o         = chain_q[LO_W-1:0];
  assign por_active_o = pa_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      chain_q <= '0;
      pa_q    <= 1'b1;
    end else if (pa_q) begin
      if (por_done) begin
        chain_q <= '0;
        pa_q    <= 1'b0;
      end else if (ce_i) begin
        chain_q <= chain_q + 1'b1;
      end
    end else if (hold_i) begin
      chain_q <= '0;
    end else if (ce_i) begin
      chain_q <= chain_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctmr_events.sv
module ctmr_events
  import ctmr_pkg::*;
#(
  parameter int unsigned TICK_STAGE = 10
) (
  input  logic                  clk_i,
  input  logic                  por_i,
  input  logic                  ce_i,
  input  phase_e                phase_i,
  input  cnt_t                  count_i,
  input  logic [TICK_STAGE-1:0] stage_i,
  input  logic                  clr_i,
  output logic                  tof_o,
  output logic                  tick_o
);
  logic run;
  logic wrap;
  logic tick_hit;
  logic tof_q;
  logic tick_q;

  assign run      = (phase_i == PH_RUN);
  assign wrap     = run && ce_i && (&count_i);
  assign tick_hit = run && ce_i && (&stage_i);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      tof_q <= 1'b0;
    end else if (!run) begin
      tof_q <= 1'b0;
    end else if (wrap) begin
      tof_q <= 1'b1;
    end else if (clr_i) begin
      tof_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_hit;
    end
  end

  assign tof_o  = tof_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/ctmr_regbus.sv
module ctmr_regbus
  import ctmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     por_i,
  input  logic     req_valid_i,
  output logic     req_ready_o,
  input  bus_req_t req_i,
  output logic     rsp_valid_o,
  input  logic     rsp_ready_i,
  output cnt_t     rsp_data_o,
  input  cnt_t     count_i,
  input  logic     tof_i,
  output logic     clr_o
);
  logic rsp_valid_q;
  cnt_t hold_q;
  logic accept;
  cnt_t rd_mux;
  logic unused_wdata;

  assign req_ready_o  = !rsp_valid_q;
  assign accept       = req_valid_i && !rsp_valid_q;
  assign clr_o        = accept && req_i.write && (req_i.addr == REG_STATUS)
                        && req_i.wdata[TOF_CLR_BIT];
  assign unused_wdata = ^req_i.wdata[CNT_W-1:1];

  always_comb begin
    if (req_i.write) begin
      rd_mux = '0;
    end else if (req_i.addr == REG_COUNT) begin
      rd_mux = count_i;
    end else begin
      rd_mux = '0;
      rd_mux[TOF_CLR_BIT] = tof_i;
    end
  end

  // Snapshot taken at the accepting edge keeps the read coherent
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      rsp_valid_q <= 1'b0;
      hold_q      <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      hold_q      <= rd_mux;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = hold_q;
endmodule

// File: rtl/core_timer.sv
module core_timer
  import ctmr_pkg::*;
#(
  parameter int unsigned CE_DIV     = 4,
  parameter int unsigned CHAIN_W    = 14,
  parameter int unsigned POR_CYCLES = 4064,
  parameter int unsigned TICK_STAGE = 10
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             ext_rst_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_addr_i,
  input  logic [CNT_W-1:0] req_wdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [CNT_W-1:0] rsp_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tof_o,
  output logic             tick_o,
  output logic             por_active_o,
  output logic             rst_out_o
);
  localparam int unsigned LO_W = (TICK_STAGE > CNT_W) ? TICK_STAGE : CNT_W;

  logic            ce;
  logic            por_active;
  logic [LO_W-1:0] lo;
  logic            clr;
  phase_e          phase;
  bus_req_t        req;

  always_comb begin
    if (por_active)     phase = PH_POWERUP;
    else if (ext_rst_i) phase = PH_HELD;
    else                phase = PH_RUN;
  end

  assign req = '{write: req_write_i, addr: req_addr_i, wdata: req_wdata_i};

  ctmr_prescale #(.DIV(CE_DIV)) u_pre (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .clear_i(phase == PH_HELD),
    .ce_o   (ce)
  );

  ctmr_chain #(
    .CHAIN_W   (CHAIN_W),
    .LO_W      (LO_W),
    .POR_CYCLES(POR_CYCLES)
  ) u_chain (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .ce_i        (ce),
    .hold_i      (ext_rst_i),
    .lo_o        (lo),
    .por_active_o(por_active)
  );

  ctmr_events #(.TICK_STAGE(TICK_STAGE)) u_evt (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .ce_i   (ce),
    .phase_i(phase),
    .count_i(lo[CNT_W-1:0]),
    .stage_i(lo[TICK_STAGE-1:0]),
    .clr_i  (clr),
    .tof_o  (tof_o),
    .tick_o (tick_o)
  );

  ctmr_regbus u_bus (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_i      (req),
    .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i),
    .rsp_data_o (rsp_data_o),
    .count_i    (lo[CNT_W-1:0]),
    .tof_i      (tof_o),
    .clr_o      (clr)
  );

  assign count_o      = lo[CNT_W-1:0];
  assign por_active_o = por_active;
  assign rst_out_o    = por_active | ext_rst_i;
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker
  import ctmr_pkg::*;
(
  input logic clk_i,
  input logic por_i,
  input logic ext_rst_i,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic req_write_i,
  input logic req_addr_i,
  input logic clr_bit_i,
  input logic rsp_valid_o,
  input logic rsp_ready_i,
  input cnt_t rsp_data_o,
  input cnt_t count_o,
  input logic tof_o,
  input logic tick_o,
  input logic por_active_o
);
  // R2: the counter only steps by one or returns to zero
  a_r2_count_step: assert property (@(posedge clk_i) disable iff (por_i)
    (count_o != $past(count_o)) |-> (count_o == CNT_W'($past(count_o) + 1'b1) || count_o == '0));

  // R3: the release edge leaves the chain cleared
  a_r3_release_clear: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_active_o) |-> (count_o == '0));

  // R3: once released, only a power-on pulse brings the phase back
  a_r3_stays_released: assert property (@(posedge clk_i) disable iff (por_i)
    !por_active_o |=> !por_active_o);

  // R5: external reset in normal operation clears count, flag and tick
  a_r5_ext_clear: assert property (@(posedge clk_i) disable iff (por_i)
    (!por_active_o && ext_rst_i) |=> (count_o == '0 && !tof_o && !tick_o));

  // R6: no overflow flag during the power-on phase
  a_r6_no_tof_in_por: assert property (@(posedge clk_i) disable iff (por_i)
    por_active_o |-> !tof_o);

  // R7: a clear away from a wrap drops the flag
  a_r7_clear: assert property (@(posedge clk_i) disable iff (por_i)
    (req_valid_i && req_ready_o && req_write_i && req_addr_i && clr_bit_i && count_o != '1)
    |=> !tof_o);

  // R9: tick is a single-cycle pulse
  a_r9_tick_single: assert property (@(posedge clk_i) disable iff (por_i)
    tick_o |=> !tick_o);

  // R10: a stalled response keeps valid and data
  a_r10_rsp_hold: assert property (@(posedge clk_i) disable iff (por_i)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
endmodule

bind core_timer ctmr_checker u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .ext_rst_i   (ext_rst_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .clr_bit_i   (req_wdata_i[0]),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_data_o  (rsp_data_o),
  .count_o     (count_o),
  .tof_o       (tof_o),
  .tick_o      (tick_o),
  .por_active_o(por_active_o)
);

// File: tb/core_timer_tb_top.sv
`timescale 1ns/1ps
module core_timer_tb_top;
  localparam int DIV       = 4;
  localparam int CW        = 14;
  localparam int POR_N     = 4064;
  localparam int TST       = 10;
  localparam int TICK_PER  = 1 << TST;
  localparam int CHAIN_MOD = 1 << CW;
  localparam int POR_EDGES = POR_N * DIV;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       ext_rst_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_write_i = 1'b0;
  logic       req_addr_i = 1'b0;
  logic [7:0] req_wdata_i = '0;
  logic       rsp_ready_i = 1'b0;
  logic       req_ready_o, rsp_valid_o, tof_o, tick_o, por_active_o, rst_out_o;
  logic [7:0] rsp_data_o, count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  core_timer dut_i (
    .clk_i(clk), .por_i(por_i), .ext_rst_i(ext_rst_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o),
    .count_o(count_o), .tof_o(tof_o), .tick_o(tick_o),
    .por_active_o(por_active_o), .rst_out_o(rst_out_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int m_pre = 0, m_chain = 0, m_pa = 1, m_tof = 0, m_tick = 0, m_rv = 0, m_rd = 0;
  int m_ce, m_run, m_acc, m_clr, m_wrap, m_old_tof;

  always @(posedge clk) begin
    if (por_i) begin
      m_pre = 0; m_chain = 0; m_pa = 1; m_tof = 0; m_tick = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_ce      = (m_pre == DIV - 1);
      m_run     = (!m_pa && !ext_rst_i);
      m_acc     = (req_valid_i && !m_rv);
      m_clr     = (m_acc && req_write_i && req_addr_i && req_wdata_i[0]);
      m_wrap    = (m_run && m_ce && (m_chain % 256 == 255));
      m_tick    = (m_run && m_ce && (m_chain % TICK_PER == TICK_PER - 1));
      m_old_tof = m_tof;
      if (!m_run) m_tof = 0;
      else if (m_wrap) m_tof = 1;
      else if (m_clr) m_tof = 0;
      if (m_acc) begin
        m_rv = 1;
        m_rd = req_write_i ? 0 : (req_addr_i ? m_old_tof : m_chain % 256);
      end else if (m_rv && rsp_ready_i) begin
        m_rv = 0;
      end
      if (m_pa) begin
        m_pre = (m_pre + 1) % DIV;
        if (m_ce) begin
          if (m_chain == POR_N - 1) begin m_chain = 0; m_pa = 0; end
          else m_chain = m_chain + 1;
        end
      end else if (ext_rst_i) begin
        m_pre = 0; m_chain = 0;
      end else begin
        m_pre = (m_pre + 1) % DIV;
        if (m_ce) m_chain = (m_chain + 1) % CHAIN_MOD;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk("R2 model count", count_o, m_chain % 256);
      chk("R3 model por_active", por_active_o, m_pa);
      chk("R5 model rst_out", rst_out_o, (m_pa != 0) || ext_rst_i);
      chk("R6 model tof", tof_o, m_tof);
      chk("R9 model tick", tick_o, m_tick);
      chk("R10 model rsp_valid", rsp_valid_o, m_rv);
      chk("R10 model req_ready", req_ready_o, !m_rv);
      if (m_rv != 0) chk("R11 model rsp_data", rsp_data_o, m_rd);
    end
  end

  task automatic bus_op(input bit wr, input bit ad, input logic [7:0] wd, input int stall,
                        output logic [7:0] rd, output logic [7:0] cnt_seen);
    logic [7:0] first;
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = ad; req_wdata_i = wd;
    cnt_seen = count_o;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R10 response raised", rsp_valid_o, 1);
    chk("R10 ready low while pending", req_ready_o, 0);
    first = rsp_data_o;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10 data held under stall", rsp_data_o, first);
      chk("R10 valid held under stall", rsp_valid_o, 1);
    end
    rsp_ready_i = 1'b1;
    rd = rsp_data_o;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    chk("R10 response retired", rsp_valid_o, 0);
  endtask

  initial begin
    logic [7:0] rd, seen;
    int n, ticks;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count_o, 0);
    chk("R1 por_active in reset", por_active_o, 1);
    chk("R1 tof in reset", tof_o, 0);
    chk("R1 tick in reset", tick_o, 0);
    chk("R1 rsp_valid in reset", rsp_valid_o, 0);
    chk("R1 rst_out in reset", rst_out_o, 1);

    // First power-on sequence with external reset activity inside it
    por_i = 1'b0;
    repeat (2000) @(negedge clk);
    ext_rst_i = 1'b1;
    repeat (50) @(negedge clk);
    ext_rst_i = 1'b0;
    repeat (POR_EDGES - 2050 - 100) @(negedge clk);
    ext_rst_i = 1'b1;
    repeat (99) @(negedge clk);
    chk("R3 por_active one edge before release", por_active_o, 1);
    chk("R4 sequence unaffected by ext reset", por_active_o, 1);
    @(negedge clk);
    chk("R3 por_active falls on time", por_active_o, 0);
    chk("R3 chain cleared at release", count_o, 0);
    chk("R5 rst_out held by ext reset", rst_out_o, 1);
    repeat (40) @(negedge clk);
    chk("R4 count held at zero", count_o, 0);
    ext_rst_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no step before fourth edge", count_o, 0);
    @(negedge clk);
    chk("R2 first step on fourth edge", count_o, 1);
    chk("R5 rst_out low in run", rst_out_o, 0);

    // Reads with and without back-pressure
    bus_op(1'b0, 1'b0, 8'h00, 0, rd, seen);
    chk("R11 read count no stall", rd, seen);
    repeat (5) @(negedge clk);
    bus_op(1'b0, 1'b0, 8'h00, 3, rd, seen);
    chk("R11 read count with stall", rd, seen);
    repeat (2) @(negedge clk);
    bus_op(1'b0, 1'b0, 8'h00, 6, rd, seen);
    chk("R11 read count long stall", rd, seen);

    // Counter writes are ignored
    bus_op(1'b1, 1'b0, 8'hA5, 0, rd, seen);
    chk("R8 write to counter ignored", ((count_o - seen) & 8'hFF) <= 1, 1);
    chk("R11 write returns zero", rd, 0);

    // Wrap sets the flag
    while (count_o != 8'hFF) @(negedge clk);
    while (count_o == 8'hFF) @(negedge clk);
    chk("R6 tof set on wrap", tof_o, 1);
    bus_op(1'b1, 1'b1, 8'h00, 0, rd, seen);
    chk("R7 write of zero keeps flag", tof_o, 1);
    bus_op(1'b0, 1'b1, 8'h00, 1, rd, seen);
    chk("R11 status read shows flag", rd, 1);
    bus_op(1'b1, 1'b1, 8'h01, 0, rd, seen);
    chk("R7 write of one clears flag", tof_o, 0);
    bus_op(1'b0, 1'b1, 8'h00, 0, rd, seen);
    chk("R11 status read after clear", rd, 0);

    // Clear landing on the wrap edge
    while (count_o == 8'hFF) @(negedge clk);
    while (count_o != 8'hFF) @(negedge clk);
    repeat (3) @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 1'b1; req_wdata_i = 8'h01;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R7 wrap wins over clear", tof_o, 1);
    chk("R6 counter wrapped", count_o, 0);
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;

    // External reset during run
    ext_rst_i = 1'b1;
    @(negedge clk);
    chk("R5 count cleared", count_o, 0);
    chk("R5 tof cleared", tof_o, 0);
    chk("R5 rst_out high", rst_out_o, 1);
    repeat (7) @(negedge clk);
    chk("R5 count stays cleared", count_o, 0);
    ext_rst_i = 1'b0;

    // Tick period
    ticks = 0;
    for (int i = 0; i < 3 * TICK_PER * DIV + 10; i++) begin
      @(negedge clk);
      if (tick_o) ticks++;
    end
    chk("R9 tick count in window", ticks, 3);

    // Power-on restart in mid-run
    por_i = 1'b1;
    @(negedge clk);
    chk("R3 restart por_active", por_active_o, 1);
    chk("R1 restart count", count_o, 0);
    por_i = 1'b0;
    n = 0;
    while (por_active_o) begin
      @(negedge clk);
      n++;
    end
    chk("R3 restart delay length", n, POR_EDGES);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule